// File: doc/BRIEF.md
# Dual-Issue Microcode Fetch Sequencer

This block steps a vector coprocessor through its microprogram, one 64-bit instruction pair per clock. The upper half of each pair feeds the upper execution slot and the lower half feeds the lower slot. The block decodes four control flags carried in the upper word:

- an immediate marker, which makes the lower word a constant for the immediate register;
- a deferred end-of-program flag;
- a debug break;
- a trace stop.

The block owns the program counter, the running bit and two sticky interrupt cause bits. The execution units are outside the block. They appear only as a branch request with a target.

Program memory is read through an asynchronous port. The address is the byte address of the current pair. Software or a host starts a program by pulsing `start_i` with a pair index. End and taken branches both take effect one pair late, so the pair after the one that triggers them always runs. If the program stops while a branch is still waiting on its delay slot, that slot is still fetched before the sequencer goes idle.

Top module: `mseq_top`

## Requirements
- R1: While reset is held and after its release, `stat_o` is zero, `irq_o` and `flush_o` are low, `slot_valid_o` is low and `mem_addr_o` is zero.
- R2: A pulse on `start_i` makes the next fetch come from byte address `start_addr_i*8` and sets the running bit, `stat_o[8]`.
- R3: While running, each cycle fetches one pair (`slot_valid_o` high) and the next fetch address is 8 bytes higher, wrapping to 0 past the top of the `2**ADDR_W`-byte program memory.
- R4: For a fetched pair, `up_insn_o` is `mem_data_i[63:32]` and `up_op_o` is its bits 5:0. `lo_insn_o` is `mem_data_i[31:0]` and `lo_op_o` is its bits 31:25.
- R5: When bit 31 of the upper word is set, `lo_valid_o` is low for that pair, and one cycle later `imm_o` holds the lower word. Otherwise `lo_valid_o` equals `slot_valid_o`.
- R6: An end flag (bit 30 of the upper word) lets exactly one more pair run, then clears `stat_o[8]` and pulses `flush_o` for one cycle, after which no pair is fetched. An end flag on that following pair restarts the one-pair wait.
- R7: A debug break (upper bit 28) with `ctrl_en_i[0]` set sets `stat_o[9]` and pulses `irq_o` for one cycle. With the enable clear it changes neither.
- R8: A trace stop (upper bit 27) with `ctrl_en_i[1]` set sets `stat_o[10]` and pulses `irq_o`. With the enable clear it changes neither.
- R9: `stat_o[9]` and `stat_o[10]` stay set across later steps and after halting until `stat_clr_i[0]` or `stat_clr_i[1]` respectively is pulsed, and clearing one leaves the other.
- R10: A branch request during a pair at address A makes the next fetch come from A+8 (the delay slot) and the fetch after that from `br_target_i*8`.
- R11: If the running bit falls while a branch delay slot is still pending, that slot pair is still fetched, then the program counter takes the branch target and fetching stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | ADDR_W-3 | Start pair index |
| ctrl_en_i | input | 2 | [0] debug break enable, [1] trace stop enable |
| stat_clr_i | input | 2 | Write-one-to-clear: [0] debug cause, [1] trace cause |
| br_req_i | input | 1 | Branch taken by the lower slot in the current pair |
| br_target_i | input | ADDR_W-3 | Branch target pair index |
| mem_addr_o | output | ADDR_W | Byte address of the pair being fetched |
| mem_data_i | input | 64 | Pair read from program memory |
| slot_valid_o | output | 1 | A pair is being stepped this cycle |
| up_insn_o | output | 32 | Upper-slot instruction word |
| up_op_o | output | 6 | Upper-slot opcode |
| lo_insn_o | output | 32 | Lower-slot instruction word |
| lo_op_o | output | 7 | Lower-slot opcode |
| lo_valid_o | output | 1 | Lower word is an instruction to execute |
| imm_o | output | 32 | Immediate register |
| flush_o | output | 1 | One-cycle pulse when the program ends |
| stat_o | output | 16 | Status: [8] running, [9] debug cause, [10] trace cause, others zero |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The fetch stream is exercised in several ways:

- A plain run tells sequential stepping apart from a re-armed end.
- A run that crosses the top of memory exposes wrapping.
- A run through an immediate pair separates executed lower words from constants.
- A run with a taken branch shows the one-pair delay.

Flag runs use the debug and trace enables one at a time, so a missing gate and a wrongly routed cause bit give different results. A final run puts a branch in the pair after an end flag. That case separates a sequencer that drains its pending delay slot from one that stops at once or keeps running.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int FLAG_IMM = 31;
    localparam int FLAG_END = 30;
    localparam int FLAG_DBG = 28;
    localparam int FLAG_TRC = 27;

    localparam int ST_RUN = 8;
    localparam int ST_DBG = 9;
    localparam int ST_TRC = 10;

    typedef struct packed {
        logic imm;
        logic fin;
        logic dbg;
        logic trc;
    } pair_flags_t;
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
    import mseq_pkg::*;
(
    input  logic [63:0]  pair_i,
    output pair_flags_t  flags_o,
    output logic [31:0]  up_o,
    output logic [31:0]  lo_o,
    output logic [5:0]   up_op_o,
    output logic [6:0]   lo_op_o
);
    always_comb begin
        up_o          = pair_i[63:32];
        lo_o          = pair_i[31:0];
        flags_o.imm   = up_o[FLAG_IMM];
        flags_o.fin   = up_o[FLAG_END];
        flags_o.dbg   = up_o[FLAG_DBG];
        flags_o.trc   = up_o[FLAG_TRC];
        up_op_o       = up_o[5:0];
        lo_op_o       = lo_o[31:25];
    end
endmodule

// File: rtl/mseq_delay.sv
// One-pair deferred action: armed by a step, fires on the next step unless re-armed.
module mseq_delay (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic arm_i,
    output logic pend_o,
    output logic fire_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i)       pend_d = 1'b0;
        else if (step_i) pend_d = arm_i;
        fire_o = step_i & pend_q & ~arm_i;
        pend_o = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-4:0] start_addr_i,
    input  logic [1:0]        ctrl_en_i,
    input  logic [1:0]        stat_clr_i,
    input  logic              br_req_i,
    input  logic [ADDR_W-4:0] br_target_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [63:0]       mem_data_i,
    output logic              slot_valid_o,
    output logic [31:0]       up_insn_o,
    output logic [5:0]        up_op_o,
    output logic [31:0]       lo_insn_o,
    output logic [6:0]        lo_op_o,
    output logic              lo_valid_o,
    output logic [31:0]       imm_o,
    output logic              flush_o,
    output logic [15:0]       stat_o,
    output logic              irq_o
);
    localparam int PAIR_W = ADDR_W - 3;

    typedef struct packed {
        logic [PAIR_W-1:0] pc;
        logic [PAIR_W-1:0] tgt;
        logic              run;
        logic              dbg;
        logic              trc;
        logic              irq;
        logic              flush;
        logic [31:0]       imm;
    } state_t;

    state_t      st_d, st_q;
    pair_flags_t flags;
    logic        step, live, end_arm, br_arm;
    logic        end_pend, end_fire, br_pend, br_fire;
    logic        dbg_set, trc_set;

    mseq_decode u_dec (
        .pair_i  (mem_data_i),
        .flags_o (flags),
        .up_o    (up_insn_o),
        .lo_o    (lo_insn_o),
        .up_op_o (up_op_o),
        .lo_op_o (lo_op_o)
    );

    mseq_delay u_end (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .step_i (step),
        .arm_i  (end_arm),
        .pend_o (end_pend),
        .fire_o (end_fire)
    );

    mseq_delay u_br (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .step_i (step),
        .arm_i  (br_arm),
        .pend_o (br_pend),
        .fire_o (br_fire)
    );

    always_comb begin
        // A step runs while live, or once more to drain a pending slot.
        live    = st_q.run;
        step    = live | end_pend | br_pend;
        end_arm = step & live & flags.fin;
        br_arm  = step & live & br_req_i;
        dbg_set = step & live & flags.dbg & ctrl_en_i[0];
        trc_set = step & live & flags.trc & ctrl_en_i[1];

        st_d       = st_q;
        st_d.irq   = dbg_set | trc_set;
        st_d.flush = 1'b0;
        st_d.dbg   = (st_q.dbg & ~stat_clr_i[0]) | dbg_set;
        st_d.trc   = (st_q.trc & ~stat_clr_i[1]) | trc_set;

        if (step) begin
            st_d.pc = br_fire ? st_q.tgt : st_q.pc + 1'b1;
            if (br_arm)    st_d.tgt = br_target_i;
            if (flags.imm) st_d.imm = lo_insn_o;
            if (end_fire) begin
                st_d.run   = 1'b0;
                st_d.flush = 1'b1;
            end
        end

        if (start_i) begin
            st_d.pc  = start_addr_i;
            st_d.run = 1'b1;
        end

        mem_addr_o   = {st_q.pc, 3'b000};
        slot_valid_o = step;
        lo_valid_o   = step & ~flags.imm;
        imm_o        = st_q.imm;
        flush_o      = st_q.flush;
        irq_o        = st_q.irq;
        stat_o         = '0;
        stat_o[ST_RUN] = st_q.run;
        stat_o[ST_DBG] = st_q.dbg;
        stat_o[ST_TRC] = st_q.trc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-4:0] start_addr_i,
    input logic [1:0]        stat_clr_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [63:0]       mem_data_i,
    input logic              slot_valid_o,
    input logic              lo_valid_o,
    input logic              flush_o,
    input logic [15:0]       stat_o,
    input logic              irq_o
);
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mem_addr_o == {$past(start_addr_i), 3'b000}) && stat_o[8]);

    a_r5_imm_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid_o && mem_data_i[63]) |-> !lo_valid_o);

    a_r6_flush_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && !$past(start_i)) |-> !stat_o[8]);

    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_o[9] || stat_o[10]));

    a_r9_dbg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[9] && !stat_clr_i[0]) |=> stat_o[9]);

    a_r9_trc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[10] && !stat_clr_i[1]) |=> stat_o[10]);

    a_r1_lo_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid_o |-> slot_valid_o);
endmodule

bind mseq_top mseq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .stat_clr_i   (stat_clr_i),
    .mem_addr_o   (mem_addr_o),
    .mem_data_i   (mem_data_i),
    .slot_valid_o (slot_valid_o),
    .lo_valid_o   (lo_valid_o),
    .flush_o      (flush_o),
    .stat_o       (stat_o),
    .irq_o        (irq_o)
);

// File: tb/mseq_top_tb_top.sv
`timescale 1ns/1ps
module mseq_top_tb_top;
    localparam int AW    = 8;
    localparam int NPAIR = 1 << (AW - 3);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-4:0] start_addr_i = '0;
    logic [1:0]    ctrl_en_i = '0;
    logic [1:0]    stat_clr_i = '0;
    logic          br_req_i;
    logic [AW-4:0] br_target_i;
    logic [AW-1:0] mem_addr_o;
    logic [63:0]   mem_data_i;
    logic          slot_valid_o, lo_valid_o, flush_o, irq_o;
    logic [31:0]   up_insn_o, lo_insn_o, imm_o;
    logic [5:0]    up_op_o;
    logic [6:0]    lo_op_o;
    logic [15:0]   stat_o;

    logic [63:0] mem [NPAIR];
    logic        br_arm = 1'b0;
    int          br_at = 0;
    logic [AW-4:0] br_tgt = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int irq_seen = 0, flush_seen = 0;

    typedef struct {
        int          addr;
        logic [63:0] word;
    } exp_t;
    exp_t        exp_q[$];
    logic        imm_due = 1'b0;
    logic [31:0] imm_exp = '0;

    always #2.5 clk = ~clk;

    assign mem_data_i  = mem[mem_addr_o[AW-1:3]];
    assign br_req_i    = br_arm && slot_valid_o && (int'(mem_addr_o) == br_at);
    assign br_target_i = br_tgt;

    mseq_top #(.ADDR_W(AW)) dut_i (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            report();
        end
    end

    // Monitor: pops the scoreboard on every stepped pair.
    always @(negedge clk) begin
        if (rst_n) begin
            if (imm_due) begin
                check(imm_o == imm_exp, "R5 imm", imm_o, imm_exp);
                imm_due = 1'b0;
            end
            if (irq_o)   irq_seen++;
            if (flush_o) flush_seen++;
            if (slot_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 extra fetch", mem_addr_o, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(mem_addr_o) == e.addr, "R3 fetch addr", mem_addr_o, e.addr);
                    check(up_insn_o == e.word[63:32] && lo_insn_o == e.word[31:0],
                          "R4 words", {up_insn_o, lo_insn_o}, e.word);
                    check(up_op_o == e.word[37:32] && lo_op_o == e.word[31:25],
                          "R4 opcodes", {up_op_o, lo_op_o}, {e.word[37:32], e.word[31:25]});
                    check(lo_valid_o == !e.word[63], "R5 lo_valid", lo_valid_o, !e.word[63]);
                    if (e.word[63]) begin
                        imm_due = 1'b1;
                        imm_exp = e.word[31:0];
                    end
                end
            end
        end
    end

    task automatic build_mem();
        for (int i = 0; i < NPAIR; i++)
            mem[i] = {5'b0, 21'(i * 37 + 11), 6'(i * 5 + 1), 7'(i * 3 + 2), 25'(i * 101 + 7)};
    endtask

    task automatic set_flag(input int pair, input int bitpos);
        mem[pair][32 + bitpos] = 1'b1;
    endtask

    task automatic expect_at(input int addr);
        exp_t e;
        e.addr = addr % (1 << AW);
        e.word = mem[e.addr / 8];
        exp_q.push_back(e);
    endtask

    task automatic expect_run(input int first, input int n);
        for (int k = 0; k < n; k++) expect_at(first + 8 * k);
    endtask

    task automatic start_at(input int pair);
        irq_seen   = 0;
        flush_seen = 0;
        @(posedge clk); #1;
        start_i      = 1'b1;
        start_addr_i = AW'(pair);
        @(posedge clk); #1;
        start_i = 1'b0;
        check(stat_o[8] == 1'b1, "R2 run set", stat_o[8], 1);
        check(int'(mem_addr_o) == pair * 8, "R2 start addr", mem_addr_o, pair * 8);
    endtask

    task automatic run_until_halt();
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!stat_o[8] && !slot_valid_o) break;
        end
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R6 all pairs fetched", exp_q.size(), 0);
        check(stat_o[8] == 1'b0, "R6 run cleared", stat_o[8], 0);
    endtask

    initial begin
        build_mem();
        repeat (3) @(negedge clk);
        check(stat_o == 16'h0 && !irq_o && !flush_o, "R1 reset status", stat_o, 0);
        check(!slot_valid_o && mem_addr_o == '0, "R1 reset idle", slot_valid_o, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!slot_valid_o && stat_o == 16'h0, "R1 idle after reset", stat_o, 0);

        // R6: end at 16, re-armed by end at 24 -> 0..32
        build_mem(); set_flag(2, 30); set_flag(3, 30);
        expect_run(0, 5);
        start_at(0); run_until_halt();
        check(flush_seen == 1, "R6 one flush", flush_seen, 1);

        // R3: wrap past top of memory
        build_mem(); set_flag(1, 30);
        expect_run(240, 5);
        start_at(30); run_until_halt();

        // R5: immediate pair
        build_mem(); set_flag(5, 31); set_flag(6, 30);
        expect_run(32, 4);
        start_at(4); run_until_halt();

        // R7/R8: debug enabled, trace disabled
        build_mem(); set_flag(0, 28); set_flag(1, 27); set_flag(2, 30);
        ctrl_en_i = 2'b01;
        expect_run(0, 4);
        start_at(0); run_until_halt();
        check(irq_seen == 1, "R7 one irq", irq_seen, 1);
        check(stat_o[9] == 1'b1, "R7 debug cause", stat_o[9], 1);
        check(stat_o[10] == 1'b0, "R8 trace gated", stat_o[10], 0);

        // R8/R9: trace enabled, debug cause still held
        build_mem(); set_flag(1, 27); set_flag(2, 30);
        ctrl_en_i = 2'b11;
        expect_run(0, 4);
        start_at(0); run_until_halt();
        check(irq_seen == 1, "R8 one irq", irq_seen, 1);
        check(stat_o[10] == 1'b1, "R8 trace cause", stat_o[10], 1);
        check(stat_o[9] == 1'b1, "R9 debug sticky", stat_o[9], 1);
        @(posedge clk); #1 stat_clr_i = 2'b01;
        @(posedge clk); #1 stat_clr_i = 2'b00;
        @(negedge clk);
        check(stat_o[9] == 1'b0, "R9 debug cleared", stat_o[9], 0);
        check(stat_o[10] == 1'b1, "R9 trace kept", stat_o[10], 1);
        ctrl_en_i = 2'b00;

        // R10: branch at 8 to pair 25 (200), end there
        build_mem(); set_flag(25, 30);
        br_arm = 1'b1; br_at = 8; br_tgt = 25;
        expect_at(0); expect_at(8); expect_at(16); expect_at(200); expect_at(208);
        start_at(0); run_until_halt();
        br_arm = 1'b0;

        // R11: end at 64, branch in its following pair at 72 -> drain 80
        build_mem(); set_flag(8, 30);
        br_arm = 1'b1; br_at = 72; br_tgt = 16;
        expect_run(56, 4);
        start_at(7); run_until_halt();
        br_arm = 1'b0;
        check(int'(mem_addr_o) == 128, "R11 pc at target", mem_addr_o, 128);
        check(flush_seen == 1, "R11 flush", flush_seen, 1);

        report();
    end
endmodule